// File: doc/BRIEF.md
# I2C Target with 7-bit, 10-bit and General-Call Addressing

This block is a synchronous target (slave) for a two-wire I2C bus. It samples SCL and SDA with the system clock and finds the bus events from the sampled lines. It pulls SDA low through an output enable, so the pad outside works as open-drain. The block answers to three kinds of address: its own 7-bit address, its own 10-bit address (sent as a header byte and then a low byte), and the general-call address. Bytes that the controller writes appear on a byte output with a one-cycle strobe. For bytes that the controller reads, the block samples a byte input and raises a one-cycle request each time it loads a new byte.

The low `PROG_W` bits of both own addresses are programmable. They are taken from the `sel_pins` input when the block is reset. After that they change only when a general-call command byte tells the block to reload them. One command reloads the bits and also clears the block's held state. The other reloads the bits and clears nothing. Two configuration inputs switch 10-bit matching and the general-call response on or off.

Top module: `i2c_target_xa`

## Requirements
- R1: SDA falling while SCL is high (START) puts the block into address reception from any state. This includes a repeated START during an active transfer.
- R2: SDA rising while SCL is high (STOP) ends the transfer at any point, even inside a byte. The partial byte is dropped with no `wr_valid` strobe, `sda_oe` goes low, and the block waits for a START.
- R3: A first byte whose bits 7:1 equal the own 7-bit address gets an ACK. The block holds SDA low from the SCL fall after the 8th bit until the SCL fall that ends the 9th clock. Bit 0 set to 1 selects read and bit 0 set to 0 selects write. Any other address gets no ACK.
- R4: In write mode, each data byte is shifted in MSB first, gets an ACK, and is shown on `wr_data` with a `wr_valid` strobe one cycle long.
- R5: In read mode, `rd_data` is sampled and `rd_req` pulses at each byte load. The byte is driven MSB first, and `sda_oe` changes only while SCL is low.
- R6: In read mode, a NACK from the controller (SDA high on the 9th clock) makes the block leave SDA released until the next START or STOP.
- R7: When `cfg_ten_bit_en` is 1, a header byte `11110` + own address bits 9:8 + 0 gets an ACK. The next byte gets an ACK only if it equals own address bits 7:0. Otherwise the block drops out until the next START.
- R8: The header byte with bit 0 = 1 (10-bit read) gets an ACK only after a full 10-bit match earlier in the same transfer, reached through a repeated START. A STOP clears that match.
- R9: When `cfg_ten_bit_en` is 0, 10-bit headers get no ACK. When `cfg_gc_en` is 0, the byte 0x00 gets no ACK.
- R10: General call 0x00 followed by 0x04 gets an ACK on both bytes. The programmable address bits are reloaded from `sel_pins`, and `wr_data` keeps its value.
- R11: General call 0x00 followed by 0x06 gets an ACK on both bytes. The programmable bits are reloaded, `wr_data` is cleared to 0, and any 10-bit match is dropped.
- R12: After a general call, a second byte with bit 0 = 1 (hardware call) gets no ACK and triggers no reload. Any command byte other than 0x04 and 0x06 is treated the same way.
- R13: First bytes whose bits 7:1 fall in the groups 00000xx or 11111xx never get an ACK, apart from the general call of R10/R11. This includes 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads the programmable address bits |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_ten_bit_en | input | 1 | Enables 10-bit address matching |
| cfg_gc_en | input | 1 | Enables the general-call response |
| sel_pins | input | PROG_W | Programmable low address bits, sampled on reset and on reload |
| wr_data | output | 8 | Last byte written by the controller |
| wr_valid | output | 1 | One-cycle strobe for a new `wr_data` |
| rd_data | input | 8 | Byte to be sent to the controller |
| rd_req | output | 1 | One-cycle strobe when `rd_data` is taken |

## Verification
The assertions rely on a well-behaved controller. It changes SDA only while SCL is low, except when it makes a START or STOP. It never makes a START or STOP while the target is holding SDA low. Each SCL phase must also be much longer than the synchronizer latency, so the target's responses land inside the low phase where they belong. The bench drives the bus with quarter-bit phases of 12 clocks and only moves SDA while SCL is low. Its controller model releases SDA for the whole of each read byte, so the assertions on when the output enable may change stay inside that contract.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_WDATA,
        ST_GCCMD,
        ST_ACK_WAIT,
        ST_ACK_HOLD,
        ST_RDATA,
        ST_RACK_WAIT,
        ST_RACK,
        ST_RLOAD,
        ST_IGNORE
    } tgt_state_e;

    // Synchronized line levels and the events derived from them
    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    // Result of comparing a first byte against the own addresses
    typedef struct packed {
        logic hit7;
        logic hdr10;
        logic gcall;
    } addr_hit_t;

    localparam logic [7:0] GC_CMD_RST_LOAD = 8'h06;
    localparam logic [7:0] GC_CMD_LOAD     = 8'h04;
    localparam logic [4:0] TEN_BIT_MARK    = 5'b11110;

    function automatic logic addr_reserved(input logic [6:0] a);
        return (a[6:2] == 5'b00000) || (a[6:2] == 5'b11111);
    endfunction

endpackage

// File: rtl/i2c_tgt_sampler.sv
module i2c_tgt_sampler
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_W = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    logic [SYNC_W-1:0] scl_sync;
    logic [SYNC_W-1:0] sda_sync;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_W-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_W-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s = scl_sync[SYNC_W-1];
    assign sda_s = sda_sync[SYNC_W-1];

    always_comb begin
        evt.scl_lvl  = scl_s;
        evt.sda_lvl  = sda_s;
        evt.scl_rise = scl_s & ~scl_prev;
        evt.scl_fall = ~scl_s & scl_prev;
        evt.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        evt.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
    import i2c_tgt_pkg::*;
#(
    parameter int          PROG_W = 2,
    parameter logic [6:0]  BASE7  = 7'h48,
    parameter logic [9:0]  BASE10 = 10'h2B4
) (
    input  logic [7:0]        byte_in,
    input  logic [PROG_W-1:0] prog,
    input  logic              ten_en,
    input  logic              gc_en,
    output addr_hit_t         hit,
    output logic [7:0]        own10_lo
);
    logic [6:0] own7;
    logic [9:0] own10;

    assign own7     = {BASE7[6:PROG_W], prog};
    assign own10    = {BASE10[9:PROG_W], prog};
    assign own10_lo = own10[7:0];

    always_comb begin
        hit.hit7  = (byte_in[7:1] == own7) && !addr_reserved(byte_in[7:1]);
        hit.hdr10 = ten_en && (byte_in[7:3] == TEN_BIT_MARK) &&
                    (byte_in[2:1] == own10[9:8]);
        hit.gcall = gc_en && (byte_in == 8'h00);
    end
endmodule

// File: rtl/i2c_target_xa.sv
module i2c_target_xa
    import i2c_tgt_pkg::*;
#(
    parameter int         PROG_W = 2,
    parameter logic [6:0] BASE7  = 7'h48,
    parameter logic [9:0] BASE10 = 10'h2B4,
    parameter int         SYNC_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              cfg_ten_bit_en,
    input  logic              cfg_gc_en,
    input  logic [PROG_W-1:0] sel_pins,
    output logic [7:0]        wr_data,
    output logic              wr_valid,
    input  logic [7:0]        rd_data,
    output logic              rd_req
);
    localparam int BIT_W = 3;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(7);

    line_evt_t         evt;
    addr_hit_t         hit;
    tgt_state_e        state, nxt_after_ack;
    logic [BIT_W-1:0]  bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        byte_in;
    logic [7:0]        own10_lo;
    logic [PROG_W-1:0] prog;
    logic              ten_matched;
    logic              load_now;

    // decision taken when the 8th bit of a received byte arrives
    logic       dec_ack, dec_wr, dec_load, dec_clr, dec_ten;
    tgt_state_e dec_nxt;

    i2c_tgt_sampler #(.SYNC_W(SYNC_W)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    assign byte_in = {shreg[6:0], evt.sda_lvl};

    i2c_tgt_addr_match #(.PROG_W(PROG_W), .BASE7(BASE7), .BASE10(BASE10)) u_match (
        .byte_in  (byte_in),
        .prog     (prog),
        .ten_en   (cfg_ten_bit_en),
        .gc_en    (cfg_gc_en),
        .hit      (hit),
        .own10_lo (own10_lo)
    );

    always_comb begin
        dec_ack  = 1'b0;
        dec_wr   = 1'b0;
        dec_load = 1'b0;
        dec_clr  = 1'b0;
        dec_ten  = 1'b0;
        dec_nxt  = ST_IGNORE;
        unique case (state)
            ST_ADDR: begin
                if (hit.gcall) begin
                    dec_ack = 1'b1;
                    dec_nxt = ST_GCCMD;
                end else if (hit.hdr10) begin
                    if (!byte_in[0]) begin
                        dec_ack = 1'b1;
                        dec_nxt = ST_ADDR2;
                    end else if (ten_matched) begin
                        dec_ack = 1'b1;
                        dec_nxt = ST_RDATA;
                    end
                end else if (hit.hit7) begin
                    dec_ack = 1'b1;
                    dec_nxt = byte_in[0] ? ST_RDATA : ST_WDATA;
                end
            end
            ST_ADDR2: begin
                if (byte_in == own10_lo) begin
                    dec_ack = 1'b1;
                    dec_ten = 1'b1;
                    dec_nxt = ST_WDATA;
                end
            end
            ST_WDATA: begin
                dec_ack = 1'b1;
                dec_wr  = 1'b1;
                dec_nxt = ST_WDATA;
            end
            ST_GCCMD: begin
                if (byte_in == GC_CMD_RST_LOAD) begin
                    dec_ack  = 1'b1;
                    dec_load = 1'b1;
                    dec_clr  = 1'b1;
                end else if (byte_in == GC_CMD_LOAD) begin
                    dec_ack  = 1'b1;
                    dec_load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign load_now = evt.scl_fall &&
                      (((state == ST_ACK_HOLD) && (nxt_after_ack == ST_RDATA)) ||
                       (state == ST_RLOAD));

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            nxt_after_ack <= ST_IDLE;
            bitcnt        <= '0;
            shreg         <= '0;
            sda_oe        <= 1'b0;
            prog          <= sel_pins;
            ten_matched   <= 1'b0;
            wr_data       <= '0;
            wr_valid      <= 1'b0;
            rd_req        <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_req   <= 1'b0;
            if (evt.stop) begin
                state       <= ST_IDLE;
                sda_oe      <= 1'b0;
                bitcnt      <= '0;
                ten_matched <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (load_now) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                rd_req <= 1'b1;
                bitcnt <= '0;
                state  <= ST_RDATA;
            end else begin
                unique case (state)
                    ST_ADDR, ST_ADDR2, ST_WDATA, ST_GCCMD: begin
                        if (evt.scl_rise) begin
                            shreg  <= byte_in;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                if (dec_ack) begin
                                    state         <= ST_ACK_WAIT;
                                    nxt_after_ack <= dec_nxt;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                                if (dec_wr) begin
                                    wr_data  <= byte_in;
                                    wr_valid <= 1'b1;
                                end
                                if (dec_load) prog <= sel_pins;
                                if (dec_ten) ten_matched <= 1'b1;
                                if (dec_clr) begin
                                    wr_data     <= '0;
                                    ten_matched <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_HOLD;
                        end
                    end
                    ST_ACK_HOLD: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= nxt_after_ack;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) state <= ST_RACK_WAIT;
                        end else if (evt.scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_RACK_WAIT: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) state <= evt.sda_lvl ? ST_IGNORE : ST_RLOAD;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR));  // R1
    AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));  // R2
    AST_WR_ONLY_FROM_WDATA: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(state) == ST_WDATA));  // R4
    AST_DRIVE_BEGINS_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !evt.scl_lvl);  // R5
    AST_OE_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (evt.scl_lvl && !evt.scl_rise) |-> $stable(sda_oe));  // R5
    AST_RDREQ_DRIVES_MSB: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (sda_oe == ~$past(rd_data[7])));  // R5
    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);  // R6
endmodule

// File: tb/i2c_target_xa_tb.sv
module i2c_target_xa_tb;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       ten_en = 1'b1;
    logic       gc_en = 1'b1;
    logic [1:0] sel = 2'b01;
    logic [1:0] cur_sel = 2'b01;
    logic [7:0] rd_data = 8'h00;
    logic       sda_oe;
    logic [7:0] wr_data;
    logic       wr_valid;
    logic       rd_req;
    wire        sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [7:0] last_wr = 8'h00;

    always #4 clk = ~clk;

    i2c_target_xa u_dut (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (scl_m),
        .sda_i          (sda_bus),
        .sda_oe         (sda_oe),
        .cfg_ten_bit_en (ten_en),
        .cfg_gc_en      (gc_en),
        .sel_pins       (sel),
        .wr_data        (wr_data),
        .wr_valid       (wr_valid),
        .rd_data        (rd_data),
        .rd_req         (rd_req)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                wr_cnt  <= wr_cnt + 1;
                last_wr <= wr_data;
            end
            if (rd_req) rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [7:0] a7(input logic [1:0] s, input logic rw);
        return {5'b10010, s, rw};
    endfunction
    function automatic logic [7:0] lo10(input logic [1:0] s);
        return {6'b101101, s};
    endfunction
    function automatic logic [7:0] hdr10(input logic rw);
        return {5'b11110, 2'b10, rw};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        s = sda_bus;
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(~ack, s);
    endtask

    task automatic t_reset();
        check("R2 reset sda_oe", int'(sda_oe), 0);
        check("R4 reset wr_valid", int'(wr_valid), 0);
        check("R5 reset rd_req", int'(rd_req), 0);
        check("R4 reset wr_data", int'(wr_data), 0);
    endtask

    task automatic t_write7();
        logic ack;
        int n0 = wr_cnt;
        bus_start();
        send_byte(a7(cur_sel, 1'b0), ack); check("R3 own write ack", int'(ack), 1);
        send_byte(8'hA5, ack);             check("R4 data1 ack", int'(ack), 1);
        check("R4 data1 value", int'(last_wr), 8'hA5);
        send_byte(8'h3C, ack);             check("R4 data2 ack", int'(ack), 1);
        bus_stop();
        check("R4 write count", wr_cnt - n0, 2);
        check("R4 last value", int'(last_wr), 8'h3C);
    endtask

    task automatic t_wrong7();
        logic ack;
        int n0 = wr_cnt;
        bus_start();
        send_byte(8'h90, ack); check("R3 foreign addr nack", int'(ack), 0);
        send_byte(8'h55, ack); check("R3 no ack after miss", int'(ack), 0);
        bus_stop();
        check("R3 no write after miss", wr_cnt - n0, 0);
    endtask

    task automatic t_reserved();
        logic ack;
        bus_start(); send_byte(8'h01, ack); bus_stop();
        check("R13 0x01 nack", int'(ack), 0);
        bus_start(); send_byte(8'h04, ack); bus_stop();
        check("R13 00000xx nack", int'(ack), 0);
        bus_start(); send_byte(8'hFA, ack); bus_stop();
        check("R13 11111xx nack", int'(ack), 0);
    endtask

    task automatic t_read7();
        logic ack, s;
        logic [7:0] d;
        int r0 = rd_cnt;
        rd_data = 8'hC9;
        bus_start();
        send_byte(a7(cur_sel, 1'b1), ack); check("R3 own read ack", int'(ack), 1);
        rd_data = 8'h5A;
        recv_byte(1'b1, d); check("R5 read byte1", int'(d), 8'hC9);
        rd_data = 8'h00;
        recv_byte(1'b0, d); check("R5 read byte2", int'(d), 8'h5A);
        check("R5 rd_req count", rd_cnt - r0, 2);
        bus_bit(1'b1, s);
        check("R6 bus free after nack", int'(s), 1);
        check("R6 oe low after nack", int'(sda_oe), 0);
        check("R6 no load after nack", rd_cnt - r0, 2);
        bus_stop();
    endtask

    task automatic t_stop_mid();
        logic ack, s;
        int n0 = wr_cnt;
        bus_start();
        send_byte(a7(cur_sel, 1'b0), ack);
        for (int i = 0; i < 4; i++) bus_bit(i[0], s);
        bus_stop();
        check("R2 oe low after stop", int'(sda_oe), 0);
        check("R2 partial dropped", wr_cnt - n0, 0);
        bus_start();
        send_byte(a7(cur_sel, 1'b0), ack); check("R2 restart ack", int'(ack), 1);
        send_byte(8'h11, ack);
        bus_stop();
        check("R2 fresh byte", int'(last_wr), 8'h11);
    endtask

    task automatic t_rep_start();
        logic ack;
        bus_start();
        send_byte(8'h22, ack); check("R1 miss before restart", int'(ack), 0);
        bus_start();
        send_byte(a7(cur_sel, 1'b0), ack); check("R1 ack after restart", int'(ack), 1);
        send_byte(8'h66, ack);
        bus_stop();
        check("R1 write after restart", int'(last_wr), 8'h66);
    endtask

    task automatic t_ten_write();
        logic ack;
        bus_start();
        send_byte(hdr10(1'b0), ack); check("R7 header ack", int'(ack), 1);
        send_byte(lo10(cur_sel), ack); check("R7 low byte ack", int'(ack), 1);
        send_byte(8'h77, ack); check("R7 data ack", int'(ack), 1);
        bus_stop();
        check("R7 data value", int'(last_wr), 8'h77);
        bus_start();
        send_byte(hdr10(1'b0), ack);
        send_byte(lo10(cur_sel) ^ 8'h80, ack); check("R7 low mismatch nack", int'(ack), 0);
        bus_stop();
    endtask

    task automatic t_ten_read();
        logic ack;
        logic [7:0] d;
        rd_data = 8'h3E;
        bus_start();
        send_byte(hdr10(1'b0), ack);
        send_byte(lo10(cur_sel), ack);
        bus_start();
        send_byte(hdr10(1'b1), ack); check("R8 read header ack", int'(ack), 1);
        recv_byte(1'b0, d); check("R8 read byte", int'(d), 8'h3E);
        bus_stop();
        bus_start();
        send_byte(hdr10(1'b1), ack); check("R8 read header after stop nack", int'(ack), 0);
        bus_stop();
    endtask

    task automatic t_disabled();
        logic ack;
        ten_en = 1'b0;
        bus_start(); send_byte(hdr10(1'b0), ack); bus_stop();
        check("R9 10-bit off nack", int'(ack), 0);
        ten_en = 1'b1;
        gc_en = 1'b0;
        bus_start(); send_byte(8'h00, ack); bus_stop();
        check("R9 general call off nack", int'(ack), 0);
        gc_en = 1'b1;
    endtask

    task automatic t_gc_load();
        logic ack;
        sel = 2'b10;
        bus_start();
        send_byte(8'h00, ack); check("R10 gc ack", int'(ack), 1);
        send_byte(8'h04, ack); check("R10 cmd ack", int'(ack), 1);
        bus_stop();
        check("R10 wr_data kept", int'(wr_data), 8'h77);
        bus_start(); send_byte(a7(cur_sel, 1'b0), ack); bus_stop();
        check("R10 old addr gone", int'(ack), 0);
        cur_sel = 2'b10;
        bus_start(); send_byte(a7(cur_sel, 1'b0), ack); bus_stop();
        check("R10 new addr ack", int'(ack), 1);
    endtask

    task automatic t_gc_reset();
        logic ack;
        sel = 2'b11;
        bus_start();
        send_byte(8'h00, ack); check("R11 gc ack", int'(ack), 1);
        send_byte(8'h06, ack); check("R11 cmd ack", int'(ack), 1);
        bus_stop();
        check("R11 wr_data cleared", int'(wr_data), 0);
        cur_sel = 2'b11;
        bus_start(); send_byte(a7(cur_sel, 1'b0), ack); bus_stop();
        check("R11 new addr ack", int'(ack), 1);
    endtask

    task automatic t_hw_call();
        logic ack;
        sel = 2'b00;
        bus_start();
        send_byte(8'h00, ack);
        send_byte(8'h05, ack); check("R12 hardware call nack", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'h00, ack);
        send_byte(8'h02, ack); check("R12 unknown cmd nack", int'(ack), 0);
        bus_stop();
        bus_start(); send_byte(a7(cur_sel, 1'b0), ack); bus_stop();
        check("R12 addr unchanged", int'(ack), 1);
        bus_start(); send_byte(a7(2'b00, 1'b0), ack); bus_stop();
        check("R12 no reload", int'(ack), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write7();
        t_wrong7();
        t_reserved();
        t_read7();
        t_stop_mid();
        t_rep_start();
        t_ten_write();
        t_ten_read();
        t_disabled();
        t_gc_load();
        t_gc_reset();
        t_hw_call();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule